// File: doc/BRIEF.md
# Iterative Fibonacci Calculator

This block returns the Fibonacci number F(n) for a 5-bit index n, where F(0) = 0, F(1) = 1 and each later term is the sum of the two before it. A requester places n on the index input and raises start for one clock while the block is idle. The block then performs one addition per clock in two 16-bit working registers until the loop count runs out.

It signals completion with a single-cycle done pulse and presents the result during that same cycle. The controller has only two states. The done flag and the result are plain combinational functions of the state and the working registers, so no flip-flop holds either of them. One request is handled at a time, and the block can accept the next request on the cycle after done.

Top module: `fib_iter`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle and done is low until a request is accepted.
- R2: A start that is high at a rising clock edge while the block is idle is accepted. For n of 1 or more, done is high in the cycle that follows the max(n,1)-th rising edge, counting the accepting edge as the first.
- R3: In the cycle in which done is high, result equals F(n) for every n from 1 to 24.
- R4: For n from 25 to 31, result equals F(n) modulo 2^16, because all additions wrap at 16 bits.
- R5: done is high for exactly one cycle per request, and the block is idle on the following cycle.
- R6: A start pulse that arrives while a computation is running is ignored. The running request still completes with its own result and timing.
- R7: While idle with start low, done stays low and nothing begins.
- R8: For n = 0, done still pulses, in the cycle after the accepting edge, just as it does for n = 1.
- R9: A start that is held high on the cycle after done is accepted, so back-to-back requests each complete with a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx | input | 5 | Index n of the requested term |
| start | input | 1 | Request strobe, sampled only while idle |
| result | output | 16 | Current term, valid while done is high |
| done | output | 1 | One-cycle completion flag |

## Verification
Two situations are hard to reach from the ports. The first is a start that lands in the middle of a long computation. The second is a new request that follows immediately after done, where the block passes through idle for only a single cycle. The bench reaches the first by pulsing start with a different index several cycles into an n = 20 run. It reaches the second by raising start in the done cycle and holding it across the return to idle. In both cases it then checks that the completion cycle and the result match the request that was actually accepted.

// File: rtl/fib_iter.sv
module fib_iter #(
  parameter int IDX_W = 5,
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             start,
  output logic [VAL_W-1:0] result,
  output logic             done
);
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} st_t;

  localparam logic [IDX_W-1:0] CNT_ONE = IDX_W'(1);
  localparam logic [VAL_W-1:0] VAL_ONE = VAL_W'(1);

  st_t              st;
  logic [IDX_W-1:0] cnt;
  logic [VAL_W-1:0] cur, prv;
  logic             last;

  assign last   = (cnt <= CNT_ONE);
  assign done   = (st == ST_RUN) && last;
  assign result = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      cur <= '0;
      prv <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cnt <= idx;
          cur <= VAL_ONE;
          prv <= '0;
          st  <= ST_RUN;
        end
        ST_RUN: if (!last) begin
          cnt <= cnt - CNT_ONE;
          cur <= cur + prv;
          prv <= cur;
        end else begin
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> st == ST_IDLE);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && start) |=> (st == ST_RUN && result == VAL_ONE));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && !done) |=> st == ST_RUN);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !start) |=> !done);
endmodule

// File: tb/fib_iter_tb_top.sv
module fib_iter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  idx = '0;
  logic        start = 1'b0;
  logic [15:0] result;
  logic        done;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  fib_iter dut_i (.clk(clk), .rst_n(rst_n), .idx(idx), .start(start),
                  .result(result), .done(done));

  function automatic logic [15:0] fib_ref(input int n);
    logic [15:0] a = 16'd0;
    logic [15:0] b = 16'd1;
    logic [15:0] t;
    for (int i = 0; i < n; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Call at the negedge just after the accepting edge; returns at the done cycle.
  task automatic wait_done(input int n, input string req, input bit cross_start, input logic [4:0] other);
    int edges = 1;
    int want = (n < 1) ? 1 : n;
    while (!done && edges < 40) begin
      if (cross_start && edges == 3) begin
        start = 1'b1;
        idx = other;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      edges++;
    end
    check({req, " latency"}, edges, want);
    if (n >= 1) check({req, " result"}, result, fib_ref(n));
  endtask

  task automatic issue(input int n);
    @(negedge clk);
    idx = 5'(n);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic after_done(input string req);
    @(posedge clk);
    @(negedge clk);
    check({req, " done low after pulse"}, done, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 done in reset", done, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", done, 1'b0);
  endtask

  task automatic t_idle;
    bit seen = 1'b0;
    idx = 5'd7;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check("R7 idle no done", seen, 1'b0);
  endtask

  task automatic t_single(input int n, input string req);
    issue(n);
    wait_done(n, req, 1'b0, 5'd0);
    after_done("R5");
  endtask

  task automatic t_ignore;
    issue(20);
    wait_done(20, "R6", 1'b1, 5'd3);
    after_done("R6");
  endtask

  task automatic t_b2b;
    issue(6);
    wait_done(6, "R9 first", 1'b0, 5'd0);
    idx = 5'd11;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9 idle gap done low", done, 1'b0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(11, "R9 second", 1'b0, 5'd0);
    after_done("R9");
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_single(1, "R2 n=1");
    t_single(2, "R2 n=2");
    for (int n = 3; n <= 24; n++) t_single(n, "R3");
    for (int n = 25; n <= 31; n++) t_single(n, "R4");
    t_single(0, "R8 n=0");
    t_ignore();
    t_b2b();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule